// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This unit carries out one atomic memory instruction at a time for a 64-bit core. The core hands over an operation code, a width selector, a byte address and a register operand. The unit reads the old memory value and works out the value to store. It writes that value back and returns a result for the destination register. The memory side uses two request/acknowledge channels, one for reads and one for writes. A request stays asserted, with its fields held steady, until the memory acknowledges it.

One shared datapath handles all nine read-modify-write operations at word or doubleword width. Word operations work only on the low 32 bits. The value they return to the register is sign-extended to 64 bits. The unit also runs the load-reserved / store-conditional pair through a single reservation register. That register holds a valid bit and an address tag at the granularity of an aligned 8-byte block. A load-reserved sets it. Any legal store-conditional tests it and then clears it. If the operation code or the width selector is not supported, the unit returns an illegal-instruction flag and makes no memory access.

Top module: `amo_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, mem_rd_req and mem_wr_req are 0, and the reservation is invalid, so a store-conditional issued first fails.
- R2: Codes 0x00, 0x01, 0x04, 0x08 and 0x0C store old+operand, operand, old^operand, old|operand and old&operand respectively.
- R3: Codes 0x10 and 0x14 store the signed minimum and maximum of old and operand. Codes 0x18 and 0x1C store the unsigned minimum and maximum.
- R4: Every read-modify-write and every load-reserved returns the old memory value on rsp_data. At word width that value is the low 32 bits sign-extended.
- R5: Width 3'b010 selects word, and 3'b011 selects doubleword. A word operation ignores bits 63:32 of the read data and the operand, and it writes the 32-bit result with bits 63:32 zero and mem_wr_word set.
- R6: Load-reserved (code 0x02) makes exactly one read and no write. It then records the address in the reservation.
- R7: A store-conditional (code 0x03) succeeds when the reservation is valid and its address agrees with the reservation in bits 31:3. A successful one writes the operand once (zero-extended low half at word width), makes no read, and returns 0.
- R8: A failing store-conditional makes no memory access and returns 1.
- R9: Any legal store-conditional clears the reservation, whether it succeeds or fails.
- R10: An operation code outside the eleven listed, or a width other than 3'b010 or 3'b011, gives rsp_illegal=1 and rsp_data=0. It makes no memory access and leaves the reservation unchanged.
- R11: req_ready is 1 only when the unit is idle. Each accepted request gives exactly one single-cycle rsp_valid pulse. mem_rd_req and mem_wr_req are never both high, and each stays high with a stable address until it is acknowledged.
- R12: For operations that write, rsp_valid rises only after the write has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_op | input | 5 | Operation code |
| req_width | input | 3 | Width selector (010 word, 011 doubleword) |
| req_addr | input | 32 | Byte address |
| req_opnd | input | 64 | Register operand |
| mem_rd_req | output | 1 | Read request, held until acknowledged |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_word | output | 1 | Read is word-sized |
| mem_rd_ack | input | 1 | Read acknowledge, with data valid |
| mem_rd_data | input | 64 | Read data |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_word | output | 1 | Write is word-sized |
| mem_wr_data | output | 64 | Write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | 64 | Value for the destination register |
| rsp_illegal | output | 1 | Request was not a supported operation |

## Verification
The hardest situations to reach are the reservation corner cases. These include a store-conditional to another word inside the same 8-byte block, a failing store-conditional that still wipes a reservation, and an illegal request squeezed between a load-reserved and its store-conditional that must not disturb it. Directed sequences set up each of these chains on purpose. A long random phase then draws from only four addresses, so reservation hits and misses come up often. The random phase mixes the widths, draws codes that include unsupported values, and uses acknowledge latencies from zero to two cycles.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'h00,
    OP_SWAP = 5'h01,
    OP_LR   = 5'h02,
    OP_SC   = 5'h03,
    OP_XOR  = 5'h04,
    OP_OR   = 5'h08,
    OP_AND  = 5'h0C,
    OP_MIN  = 5'h10,
    OP_MAX  = 5'h14,
    OP_MINU = 5'h18,
    OP_MAXU = 5'h1C
  } amo_op_e;

  localparam logic [2:0] SZ_WORD  = 3'b010;
  localparam logic [2:0] SZ_DWORD = 3'b011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_RESP
  } amo_state_e;

  function automatic logic op_known(input logic [4:0] code);
    return code inside {OP_ADD, OP_SWAP, OP_LR, OP_SC, OP_XOR, OP_OR,
                        OP_AND, OP_MIN, OP_MAX, OP_MINU, OP_MAXU};
  endfunction

endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [4:0]      op_i,
  input  logic            is_word_i,
  input  logic [XLEN-1:0] old_i,
  input  logic [XLEN-1:0] opnd_i,
  output logic [XLEN-1:0] new_o,
  output logic [XLEN-1:0] ret_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] s_old, s_opnd, u_old, u_opnd, res;
  logic            lt_s, lt_u;

  // Operand views: word width narrows to the low half, extended per compare kind
  always_comb begin
    if (is_word_i) begin
      s_old  = {{HALF{old_i[HALF-1]}},  old_i[HALF-1:0]};
      s_opnd = {{HALF{opnd_i[HALF-1]}}, opnd_i[HALF-1:0]};
      u_old  = {{HALF{1'b0}}, old_i[HALF-1:0]};
      u_opnd = {{HALF{1'b0}}, opnd_i[HALF-1:0]};
    end else begin
      s_old  = old_i;
      s_opnd = opnd_i;
      u_old  = old_i;
      u_opnd = opnd_i;
    end
  end

  assign lt_s = $signed(s_old) < $signed(s_opnd);
  assign lt_u = u_old < u_opnd;

  always_comb begin
    case (op_i)
      OP_ADD:  res = old_i + opnd_i;
      OP_SWAP: res = opnd_i;
      OP_XOR:  res = old_i ^ opnd_i;
      OP_OR:   res = old_i | opnd_i;
      OP_AND:  res = old_i & opnd_i;
      OP_MIN:  res = lt_s ? old_i  : opnd_i;
      OP_MAX:  res = lt_s ? opnd_i : old_i;
      OP_MINU: res = lt_u ? old_i  : opnd_i;
      OP_MAXU: res = lt_u ? opnd_i : old_i;
      default: res = old_i;
    endcase
  end

  assign new_o = is_word_i ? {{HALF{1'b0}}, res[HALF-1:0]} : res;
  assign ret_o = s_old;

endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              chk_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - GRAN_LSB;

  logic [TAG_W-1:0] set_tag, chk_tag, tag_q;
  logic             valid_q;

  generate
    if (GRAN_LSB > 0) begin : g_block
      assign set_tag = set_addr_i[ADDR_W-1:GRAN_LSB];
      assign chk_tag = chk_addr_i[ADDR_W-1:GRAN_LSB];
    end else begin : g_exact
      assign set_tag = set_addr_i;
      assign chk_tag = chk_addr_i;
    end
  endgenerate

  assign hit_o = valid_q && (tag_q == chk_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (chk_i) begin
      valid_q <= 1'b0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      tag_q   <= set_tag;
    end
  end

  // R9: a checked reservation is gone on the next cycle
  assert_sc_clears_R9: assert property (@(posedge clk) disable iff (rst)
    chk_i |=> !valid_q);

  // R6: a load-reserved leaves a valid reservation on its own block
  assert_lr_sets_R6: assert property (@(posedge clk) disable iff (rst)
    (set_i && !chk_i) |=> (valid_q && tag_q == $past(set_tag)));

endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [4:0]        req_op_i,
  input  logic [2:0]        req_width_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [XLEN-1:0]   req_opnd_i,
  input  logic              resv_hit_i,
  output logic              resv_set_o,
  output logic [ADDR_W-1:0] resv_set_addr_o,
  output logic              resv_chk_o,
  output logic [4:0]        alu_op_o,
  output logic              alu_word_o,
  output logic [XLEN-1:0]   alu_old_o,
  output logic [XLEN-1:0]   alu_opnd_o,
  input  logic [XLEN-1:0]   alu_new_i,
  input  logic [XLEN-1:0]   alu_ret_i,
  output logic              mem_rd_req_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  output logic              mem_rd_word_o,
  input  logic              mem_rd_ack_i,
  input  logic [XLEN-1:0]   mem_rd_data_i,
  output logic              mem_wr_req_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic              mem_wr_word_o,
  output logic [XLEN-1:0]   mem_wr_data_o,
  input  logic              mem_wr_ack_i,
  output logic              rsp_valid_o,
  output logic [XLEN-1:0]   rsp_data_o,
  output logic              rsp_illegal_o
);
  localparam int HALF = XLEN / 2;

  amo_state_e        state_q;
  logic [4:0]        op_q;
  logic              word_q, ill_q, sc_ok_q;
  logic [ADDR_W-1:0] addr_q;
  logic [XLEN-1:0]   opnd_q, old_q;

  logic accept, dec_word, dec_illegal, is_sc_q, is_lr_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign dec_word    = (req_width_i == SZ_WORD);
  assign dec_illegal = !(op_known(req_op_i) &&
                         (req_width_i == SZ_WORD || req_width_i == SZ_DWORD));
  assign is_sc_q     = (op_q == OP_SC);
  assign is_lr_q     = (op_q == OP_LR);

  assign resv_chk_o      = accept && !dec_illegal && (req_op_i == OP_SC);
  assign resv_set_o      = (state_q == ST_READ) && mem_rd_ack_i && is_lr_q;
  assign resv_set_addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      word_q  <= 1'b0;
      ill_q   <= 1'b0;
      sc_ok_q <= 1'b0;
      addr_q  <= '0;
      opnd_q  <= '0;
      old_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= req_op_i;
          word_q  <= dec_word;
          ill_q   <= dec_illegal;
          sc_ok_q <= resv_hit_i;
          addr_q  <= req_addr_i;
          opnd_q  <= req_opnd_i;
          if (dec_illegal)              state_q <= ST_RESP;
          else if (req_op_i == OP_SC)   state_q <= resv_hit_i ? ST_WRITE : ST_RESP;
          else                          state_q <= ST_READ;
        end
        ST_READ: if (mem_rd_ack_i) begin
          old_q   <= mem_rd_data_i;
          state_q <= is_lr_q ? ST_RESP : ST_WRITE;
        end
        ST_WRITE: if (mem_wr_ack_i) state_q <= ST_RESP;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign alu_op_o   = op_q;
  assign alu_word_o = word_q;
  assign alu_old_o  = old_q;
  assign alu_opnd_o = opnd_q;

  assign mem_rd_req_o  = (state_q == ST_READ);
  assign mem_rd_addr_o = addr_q;
  assign mem_rd_word_o = word_q;

  assign mem_wr_req_o  = (state_q == ST_WRITE);
  assign mem_wr_addr_o = addr_q;
  assign mem_wr_word_o = word_q;
  assign mem_wr_data_o = !is_sc_q ? alu_new_i :
                         word_q   ? {{HALF{1'b0}}, opnd_q[HALF-1:0]} : opnd_q;

  assign rsp_valid_o   = (state_q == ST_RESP);
  assign rsp_illegal_o = rsp_valid_o && ill_q;
  always_comb begin
    if (!rsp_valid_o || ill_q) rsp_data_o = '0;
    else if (is_sc_q)          rsp_data_o = {{(XLEN-1){1'b0}}, !sc_ok_q};
    else                       rsp_data_o = alu_ret_i;
  end

  // R11: read request and address held until acknowledged
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req_o && !mem_rd_ack_i) |=> (mem_rd_req_o && $stable(mem_rd_addr_o)));

  // R11: write request, address and data held until acknowledged
  assert_wr_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req_o && !mem_wr_ack_i) |=>
      (mem_wr_req_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));

  // R11: the two memory channels never both active
  assert_one_channel_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req_o && mem_wr_req_o));

  // R11: response is a single-cycle pulse followed by idle
  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  // R10: an illegal response follows a cycle with no memory activity
  assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal_o |-> $past(!mem_rd_req_o && !mem_wr_req_o));

  // R8: a failed store-conditional had no write in front of it
  assert_sc_fail_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && !rsp_illegal_o && is_sc_q && rsp_data_o[0]) |-> $past(!mem_wr_req_o));

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN          = 64,
  parameter int ADDR_W        = 32,
  parameter int RESV_GRAN_LSB = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [4:0]        req_op,
  input  logic [2:0]        req_width,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [XLEN-1:0]   req_opnd,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  output logic              mem_rd_word,
  input  logic              mem_rd_ack,
  input  logic [XLEN-1:0]   mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic              mem_wr_word,
  output logic [XLEN-1:0]   mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              rsp_valid,
  output logic [XLEN-1:0]   rsp_data,
  output logic              rsp_illegal
);
  logic              resv_hit, resv_set, resv_chk;
  logic [ADDR_W-1:0] resv_set_addr;
  logic [4:0]        alu_op;
  logic              alu_word;
  logic [XLEN-1:0]   alu_old, alu_opnd, alu_new, alu_ret;

  amo_ctrl #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .req_valid_i     (req_valid),
    .req_ready_o     (req_ready),
    .req_op_i        (req_op),
    .req_width_i     (req_width),
    .req_addr_i      (req_addr),
    .req_opnd_i      (req_opnd),
    .resv_hit_i      (resv_hit),
    .resv_set_o      (resv_set),
    .resv_set_addr_o (resv_set_addr),
    .resv_chk_o      (resv_chk),
    .alu_op_o        (alu_op),
    .alu_word_o      (alu_word),
    .alu_old_o       (alu_old),
    .alu_opnd_o      (alu_opnd),
    .alu_new_i       (alu_new),
    .alu_ret_i       (alu_ret),
    .mem_rd_req_o    (mem_rd_req),
    .mem_rd_addr_o   (mem_rd_addr),
    .mem_rd_word_o   (mem_rd_word),
    .mem_rd_ack_i    (mem_rd_ack),
    .mem_rd_data_i   (mem_rd_data),
    .mem_wr_req_o    (mem_wr_req),
    .mem_wr_addr_o   (mem_wr_addr),
    .mem_wr_word_o   (mem_wr_word),
    .mem_wr_data_o   (mem_wr_data),
    .mem_wr_ack_i    (mem_wr_ack),
    .rsp_valid_o     (rsp_valid),
    .rsp_data_o      (rsp_data),
    .rsp_illegal_o   (rsp_illegal)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op_i      (alu_op),
    .is_word_i (alu_word),
    .old_i     (alu_old),
    .opnd_i    (alu_opnd),
    .new_o     (alu_new),
    .ret_o     (alu_ret)
  );

  amo_resv #(.ADDR_W(ADDR_W), .GRAN_LSB(RESV_GRAN_LSB)) u_resv (
    .clk        (clk),
    .rst        (rst),
    .set_i      (resv_set),
    .set_addr_i (resv_set_addr),
    .chk_i      (resv_chk),
    .chk_addr_i (req_addr),
    .hit_o      (resv_hit)
  );

endmodule

// File: tb/test_amo_unit.sv
module test_amo_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_op = '0;
  logic [2:0]  req_width = '0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_opnd = '0;
  logic        mem_rd_req, mem_rd_word, mem_wr_req, mem_wr_word;
  logic [31:0] mem_rd_addr, mem_wr_addr;
  logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
  logic [63:0] mem_rd_data = '0, mem_wr_data;
  logic        rsp_valid, rsp_illegal;
  logic [63:0] rsp_data;

  always #5 clk = ~clk;

  amo_unit i_amo_unit (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_width(req_width), .req_addr(req_addr), .req_opnd(req_opnd),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_word(mem_rd_word),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_word(mem_wr_word),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_illegal(rsp_illegal)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] mem [logic [31:0]];
  bit          m_valid = 1'b0;
  logic [31:0] m_addr = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] memrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return {a ^ 32'hA5C3_0F11, ~a};
  endfunction

  function automatic bit legal_op(input logic [4:0] c);
    return c inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h08, 5'h0C,
                     5'h10, 5'h14, 5'h18, 5'h1C};
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] ref_new(input logic [4:0] op, input bit word,
                                          input logic [63:0] o, input logic [63:0] b);
    if (word) begin
      int          so = o[31:0];
      int          sb = b[31:0];
      int unsigned uo = o[31:0];
      int unsigned ub = b[31:0];
      int unsigned r;
      case (op)
        5'h00: r = uo + ub;
        5'h01: r = ub;
        5'h04: r = uo ^ ub;
        5'h08: r = uo | ub;
        5'h0C: r = uo & ub;
        5'h10: r = (so < sb) ? uo : ub;
        5'h14: r = (so > sb) ? uo : ub;
        5'h18: r = (uo < ub) ? uo : ub;
        default: r = (uo > ub) ? uo : ub;
      endcase
      return {32'h0, r};
    end else begin
      longint          so = o;
      longint          sb = b;
      longint unsigned uo = o;
      longint unsigned ub = b;
      case (op)
        5'h00: return uo + ub;
        5'h01: return ub;
        5'h04: return uo ^ ub;
        5'h08: return uo | ub;
        5'h0C: return uo & ub;
        5'h10: return (so < sb) ? uo : ub;
        5'h14: return (so > sb) ? uo : ub;
        5'h18: return (uo < ub) ? uo : ub;
        default: return (uo > ub) ? uo : ub;
      endcase
    end
  endfunction

  // Runs one request; enters and leaves on a falling edge
  task automatic txn(input logic [4:0] op, input logic [2:0] w, input logic [31:0] a,
                     input logic [63:0] b, input int lat, input string tag);
    bit word, legal, exp_ill, got, ok_sc, wr_word;
    logic [63:0] old, exp_rsp, exp_wd, wd, rdat;
    logic [31:0] wa;
    int exp_rd, exp_wr, nrd, nwr, cyc, wt;
    logic rill;
    word = (w == 3'b010);
    legal = legal_op(op) && (w == 3'b010 || w == 3'b011);
    old = memrd(a);
    exp_rd = 0; exp_wr = 0; exp_ill = 0; exp_rsp = '0; exp_wd = '0;
    if (!legal) exp_ill = 1;
    else if (op == 5'h02) begin
      exp_rd = 1; exp_rsp = word ? sx32(old[31:0]) : old;
      m_valid = 1; m_addr = a;
    end else if (op == 5'h03) begin
      ok_sc = m_valid && (m_addr[31:3] == a[31:3]);
      m_valid = 0;
      exp_rsp = ok_sc ? 64'd0 : 64'd1;
      if (ok_sc) begin
        exp_wr = 1; exp_wd = word ? {32'h0, b[31:0]} : b;
      end
    end else begin
      exp_rd = 1; exp_wr = 1;
      exp_wd = ref_new(op, word, old, b);
      exp_rsp = word ? sx32(old[31:0]) : old;
    end

    chk(req_ready === 1'b1, "R11", "ready when idle", {63'h0, req_ready}, 64'd1);
    req_valid = 1'b1; req_op = op; req_width = w; req_addr = a; req_opnd = b;
    @(negedge clk);
    req_valid = 1'b0;
    nrd = 0; nwr = 0; cyc = 0; wt = 0; got = 0;
    wa = '0; wd = '0; wr_word = 0; rdat = '0; rill = 1'b0;
    while (!got && cyc < 100) begin
      mem_rd_ack = 1'b0; mem_wr_ack = 1'b0;
      if (rsp_valid) begin
        got = 1; rdat = rsp_data; rill = rsp_illegal;
      end else begin
        if (req_ready) chk(0, "R11", "ready while busy", 64'd1, 64'd0);
        if (mem_rd_req) begin
          if (wt >= lat) begin
            mem_rd_ack = 1'b1; mem_rd_data = memrd(mem_rd_addr);
            chk(mem_rd_addr == a, tag, "read address", {32'h0, mem_rd_addr}, {32'h0, a});
            nrd++; wt = 0;
          end else wt++;
        end
        if (mem_wr_req) begin
          if (wt >= lat) begin
            mem_wr_ack = 1'b1; wa = mem_wr_addr; wd = mem_wr_data; wr_word = mem_wr_word;
            if (mem_wr_word) mem[mem_wr_addr] = {memrd(mem_wr_addr) >> 32, mem_wr_data[31:0]};
            else mem[mem_wr_addr] = mem_wr_data;
            nwr++; wt = 0;
          end else wt++;
        end
      end
      @(negedge clk);
      cyc++;
    end
    mem_rd_ack = 1'b0; mem_wr_ack = 1'b0;
    if (!got) begin
      chk(0, "R11", "watchdog, no response", 64'd0, 64'd1);
      return;
    end
    chk(rdat === exp_rsp, tag, "rsp_data", rdat, exp_rsp);
    chk(rill === exp_ill, exp_ill ? "R10" : tag, "rsp_illegal", {63'h0, rill}, {63'h0, exp_ill});
    chk(nrd == exp_rd, exp_ill ? "R10" : tag, "read count", nrd, exp_rd);
    chk(nwr == exp_wr, exp_wr != 0 ? "R12" : tag, "write count before response", nwr, exp_wr);
    if (exp_wr != 0 && nwr == 1) begin
      chk(wd === exp_wd, tag, "write data", wd, exp_wd);
      chk(wa == a && wr_word == word, "R5", "write address/size",
          {31'h0, wr_word, wa}, {31'h0, word, a});
    end
  endtask

  initial begin
    #(10 * 150000);
    n_bad++;
    $display("FAIL R11 global watchdog expired: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_req === 1'b0 && mem_wr_req === 1'b0,
        "R1", "reset outputs", {60'h0, req_ready, rsp_valid, mem_rd_req, mem_wr_req}, 64'h8);

    // R1: no reservation after reset
    txn(5'h03, 3'b011, 32'h100, 64'h1111, 0, "R1");

    // R2: bitwise and arithmetic, doubleword
    mem[32'h10] = 64'hFFFF_FFFF_FFFF_FFF0;
    txn(5'h00, 3'b011, 32'h10, 64'h0000_0000_0000_0020, 0, "R2");
    txn(5'h01, 3'b011, 32'h10, 64'h1234_5678_9ABC_DEF0, 1, "R2");
    txn(5'h04, 3'b011, 32'h10, 64'hFFFF_0000_FFFF_0000, 2, "R2");
    txn(5'h08, 3'b011, 32'h10, 64'h0000_0000_0000_000F, 0, "R2");
    txn(5'h0C, 3'b011, 32'h10, 64'h00FF_00FF_00FF_00FF, 1, "R2");

    // R3: signed vs unsigned selection on a negative old value
    mem[32'h18] = 64'h8000_0000_0000_0005;
    txn(5'h10, 3'b011, 32'h18, 64'd7, 0, "R3");
    mem[32'h18] = 64'h8000_0000_0000_0005;
    txn(5'h14, 3'b011, 32'h18, 64'd7, 0, "R3");
    mem[32'h18] = 64'h8000_0000_0000_0005;
    txn(5'h18, 3'b011, 32'h18, 64'd7, 2, "R3");
    mem[32'h18] = 64'h8000_0000_0000_0005;
    txn(5'h1C, 3'b011, 32'h18, 64'd7, 1, "R3");

    // R4/R5: word width, upper garbage, sign-extended return
    mem[32'h20] = 64'hDEAD_BEEF_7FFF_FFFF;
    txn(5'h00, 3'b010, 32'h20, 64'hCAFE_0000_0000_0001, 0, "R5");
    txn(5'h01, 3'b010, 32'h20, 64'h0123_4567_0000_0042, 1, "R4");
    mem[32'h28] = 64'h0000_0001_FFFF_FFFE;
    txn(5'h10, 3'b010, 32'h28, 64'hFFFF_FFFF_0000_0003, 0, "R5");
    mem[32'h28] = 64'h0000_0001_FFFF_FFFE;
    txn(5'h18, 3'b010, 32'h28, 64'hFFFF_FFFF_0000_0003, 0, "R5");

    // R6, R7, R9: reserve, succeed, then the reservation is spent
    txn(5'h02, 3'b011, 32'h200, 64'h0, 1, "R6");
    txn(5'h03, 3'b011, 32'h200, 64'hAAAA_BBBB_CCCC_DDDD, 1, "R7");
    txn(5'h03, 3'b011, 32'h200, 64'h5, 0, "R9");

    // R8, R9: mismatched block fails and still clears
    txn(5'h02, 3'b011, 32'h300, 64'h0, 0, "R6");
    txn(5'h03, 3'b011, 32'h310, 64'h9, 0, "R8");
    txn(5'h03, 3'b011, 32'h300, 64'h9, 0, "R9");

    // R7: other word of the same 8-byte block, word width
    txn(5'h02, 3'b010, 32'h400, 64'h0, 0, "R6");
    txn(5'h03, 3'b010, 32'h404, 64'hFFFF_FFFF_8765_4321, 2, "R7");

    // R10: illegal requests in the middle do not touch the reservation
    txn(5'h02, 3'b011, 32'h500, 64'h0, 0, "R6");
    txn(5'h05, 3'b011, 32'h500, 64'h1, 0, "R10");
    txn(5'h00, 3'b000, 32'h500, 64'h1, 0, "R10");
    txn(5'h03, 3'b111, 32'h500, 64'h1, 0, "R10");
    txn(5'h1F, 3'b010, 32'h500, 64'h1, 0, "R10");
    txn(5'h03, 3'b011, 32'h500, 64'h77, 0, "R7");

    // Mixed random phase over a few shared addresses
    for (int i = 0; i < 300; i++) begin
      logic [4:0]  rop;
      logic [2:0]  rw;
      logic [31:0] ra;
      int          k;
      k = $urandom_range(0, 13);
      case (k)
        0: rop = 5'h00;  1: rop = 5'h01;  2: rop = 5'h02;  3: rop = 5'h03;
        4: rop = 5'h04;  5: rop = 5'h08;  6: rop = 5'h0C;  7: rop = 5'h10;
        8: rop = 5'h14;  9: rop = 5'h18;  10: rop = 5'h1C; 11: rop = 5'h02;
        12: rop = 5'h03; default: rop = 5'($urandom_range(0, 31));
      endcase
      k = $urandom_range(0, 9);
      rw = (k < 5) ? 3'b011 : (k < 9) ? 3'b010 : 3'($urandom_range(0, 7));
      k = $urandom_range(0, 3);
      ra = (k == 0) ? 32'h600 : (k == 1) ? 32'h604 : (k == 2) ? 32'h608 : 32'h700;
      txn(rop, rw, ra, {$urandom(), $urandom()}, $urandom_range(0, 2), "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule